// File: doc/BRIEF.md
# Multi-Thread Time-Aware Gate Scheduler

This block drives the per-port, per-traffic-class transmission gates of an egress path from a cyclic time schedule. A single table of schedule entries is shared by up to eight execution threads. Each thread owns a contiguous slice of that table and starts once a free-running tick counter reaches the thread's own start offset. It then holds each entry of its slice for that entry's duration, walks to the end of the slice and wraps back to the first entry of the slice. Each entry names the destination ports it governs, the traffic classes whose gates it closes, and how many ticks it lasts. One tick stands for 200 ns of schedule time.

The configuration sits in three small write ports: entry rows, thread rows, and a global row holding the clock source and the count of active threads. These writes take effect only while `enable` is low, and there is no shadow copy. To change a schedule, the host drops `enable`, rewrites the tables and raises `enable` again. A configuration that breaks a legality rule is rejected when `enable` is raised, and the engine stays idle. The block has no data stream, so it has no valid/ready handshake. Every write strobe is accepted in the cycle it is high, with no back-pressure, and the outputs are plain level signals.

Top module: `tgs_engine`

## Requirements
- R1: After reset every gate of every port is open (`gates_open` all ones) and `collision` is low.
- R2: Entry, thread and global writes are stored only while `enable` is low. A write made while `enable` is high changes neither the running outputs nor the configuration seen after a later re-enable.
- R3: An active thread starts on the first tick, sampled while the engine runs, whose `time_now` is greater than or equal to its start offset. Before that tick the thread affects no gate.
- R4: A thread holds each entry for exactly its duration in ticks. It walks from its start address up to and including its end index, then wraps to its start address, indefinitely.
- R5: The open mask of an entry is the bitwise inverse of its closed mask. Traffic class c maps to bit c, and port p occupies `gates_open[8p+7:8p]`. The mask applies to every port set in the entry's port bitmask. A port that no current entry targets has all eight gates open. When several threads target one port, the lowest-numbered thread wins.
- R6: The active thread count is the programmed value plus one. Threads above that count stay idle.
- R7: When `enable` is high, the configuration is rejected and every gate stays open if any of the following holds:
  - an entry inside an active slice has duration 0, or a duration of 2^19 ticks or more;
  - an active thread has start offset 0;
  - an active thread has start address above its end index;
  - end indices decrease across the active threads;
  - an unused thread's end index differs from that of the last active thread.
  A duration of 2^19-1 is accepted.
- R8: Clock-source code 1 (standalone counter) runs the engine. Codes 0 (off), 2 (sync-network time) and 3 (precision time) are all treated as off.
- R9: `collision` rises in the cycle after any tick on which two or more threads load an entry. It stays high while `enable` is high and clears in the cycle after `enable` goes low.
- R10: The cycle after `enable` falls, the engine is idle and all gates are open. A later raise of `enable` starts every thread afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the engine; configuration writes are locked while high |
| tick | input | 1 | One schedule tick (200 ns) elapses this cycle |
| time_now | input | TIME_W | Free-running tick counter value for this tick |
| ent_we | input | 1 | Write one entry row |
| ent_addr | input | IDX_W | Entry row index |
| ent_dur | input | DUR_W | Entry duration in ticks |
| ent_ports | input | NPORT | Destination-port bitmask of the entry |
| ent_closed | input | 8 | Traffic classes whose gates the entry closes |
| thr_we | input | 1 | Write one thread row |
| thr_sel | input | THR_W | Thread number |
| thr_start | input | IDX_W | First entry of the thread's slice |
| thr_end | input | IDX_W | Last entry of the thread's slice |
| thr_offset | input | TIME_W | Tick count at which the thread starts |
| glb_we | input | 1 | Write the global row |
| glb_src | input | 2 | Clock-source code |
| glb_act_m1 | input | THR_W | Number of active threads minus one |
| gates_open | output | NPORT*8 | Open-gate vector, 8 bits per port |
| collision | output | 1 | Sticky simultaneous-entry-start flag |

## Verification
A thread whose index or down-counter went wrong would show at the ports no later than its next entry boundary, as a gate byte that differs from the expected value for that tick. The bench therefore compares the whole gate vector after every tick of a two-thread schedule, including the ticks where one thread wraps its slice and where a lower thread overrides a higher one on a shared port. A legality check that is too loose or too strict appears at once as gates that open or fail to open in the first ticks after `enable` rises. A lost collision bit appears in the cycle after the colliding tick.

// File: rtl/tgs_pkg.sv
package tgs_pkg;
  localparam int NUM_TC = 8;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_FREE = 2'd1,
    SRC_SYNC = 2'd2,
    SRC_PREC = 2'd3
  } clk_src_e;
endpackage

// File: rtl/tgs_cfg_store.sv
module tgs_cfg_store
  import tgs_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int NPORT   = 5,
  parameter int NTHR    = 8,
  parameter int TIME_W  = 32,
  parameter int MAX_DUR = 2**19,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int DUR_W  = $clog2(MAX_DUR) + 1,
  localparam int THR_W  = $clog2(NTHR)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_ok,
  input  logic                                ent_we,
  input  logic [IDX_W-1:0]                    ent_addr,
  input  logic [DUR_W-1:0]                    ent_dur,
  input  logic [NPORT-1:0]                    ent_ports,
  input  logic [NUM_TC-1:0]                   ent_closed,
  input  logic                                thr_we,
  input  logic [THR_W-1:0]                    thr_sel,
  input  logic [IDX_W-1:0]                    thr_start,
  input  logic [IDX_W-1:0]                    thr_end,
  input  logic [TIME_W-1:0]                   thr_offset,
  input  logic                                glb_we,
  input  logic [1:0]                          glb_src,
  input  logic [THR_W-1:0]                    glb_act_m1,
  output logic [DEPTH-1:0][DUR_W-1:0]         e_dur,
  output logic [DEPTH-1:0][NPORT-1:0]         e_ports,
  output logic [DEPTH-1:0][NUM_TC-1:0]        e_closed,
  output logic [NTHR-1:0][IDX_W-1:0]          t_start,
  output logic [NTHR-1:0][IDX_W-1:0]          t_end,
  output logic [NTHR-1:0][TIME_W-1:0]         t_off,
  output logic [THR_W-1:0]                    act_m1,
  output logic                                cfg_ok
);

  clk_src_e src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_dur    <= '0;
      e_ports  <= '0;
      e_closed <= '0;
      t_start  <= '0;
      t_end    <= '0;
      t_off    <= '0;
      act_m1   <= '0;
      src_q    <= SRC_OFF;
    end else if (wr_ok) begin
      if (ent_we) begin
        e_dur[ent_addr]    <= ent_dur;
        e_ports[ent_addr]  <= ent_ports;
        e_closed[ent_addr] <= ent_closed;
      end
      if (thr_we) begin
        t_start[thr_sel] <= thr_start;
        t_end[thr_sel]   <= thr_end;
        t_off[thr_sel]   <= thr_offset;
      end
      if (glb_we) begin
        src_q  <= clk_src_e'(glb_src);
        act_m1 <= glb_act_m1;
      end
    end
  end

  // Legality of the whole stored configuration
  always_comb begin
    logic covered;
    cfg_ok = (src_q == SRC_FREE);
    for (int t = 0; t < NTHR; t++) begin
      if (t <= int'(act_m1)) begin
        if (t_off[t] == '0) cfg_ok = 1'b0;
        if (t_start[t] > t_end[t]) cfg_ok = 1'b0;
      end else if (t_end[t] != t_end[act_m1]) begin
        cfg_ok = 1'b0;
      end
    end
    for (int t = 1; t < NTHR; t++) begin
      if (t <= int'(act_m1) && t_end[t] < t_end[t-1]) cfg_ok = 1'b0;
    end
    for (int k = 0; k < DEPTH; k++) begin
      covered = 1'b0;
      for (int t = 0; t < NTHR; t++) begin
        if (t <= int'(act_m1) && k >= int'(t_start[t]) && k <= int'(t_end[t]))
          covered = 1'b1;
      end
      if (covered && (e_dur[k] == '0 || int'(e_dur[k]) >= MAX_DUR))
        cfg_ok = 1'b0;
    end
  end

endmodule

// File: rtl/tgs_thread.sv
module tgs_thread #(
  parameter int IDX_W  = 4,
  parameter int DUR_W  = 20,
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              act,
  input  logic              tick,
  input  logic [TIME_W-1:0] time_now,
  input  logic [TIME_W-1:0] off,
  input  logic [IDX_W-1:0]  first,
  input  logic [IDX_W-1:0]  last,
  input  logic [DUR_W-1:0]  nxt_dur,
  output logic [IDX_W-1:0]  nxt_idx,
  output logic [IDX_W-1:0]  idx,
  output logic              started,
  output logic              evt
);

  logic [DUR_W-1:0] rem;

  always_comb begin
    nxt_idx = (!started || idx == last) ? first : idx + 1'b1;
    evt     = run && act && tick && (started ? (rem == '0) : (time_now >= off));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      idx     <= '0;
      rem     <= '0;
    end else if (!run || !act) begin
      started <= 1'b0;
      rem     <= '0;
    end else if (evt) begin
      started <= 1'b1;
      idx     <= nxt_idx;
      rem     <= nxt_dur - 1'b1;
    end else if (tick && started) begin
      rem <= rem - 1'b1;
    end
  end

endmodule

// File: rtl/tgs_gate_mux.sv
module tgs_gate_mux
  import tgs_pkg::*;
#(
  parameter int NPORT = 5,
  parameter int NTHR  = 8
) (
  input  logic [NTHR-1:0]                  live,
  input  logic [NTHR-1:0][NPORT-1:0]       cur_ports,
  input  logic [NTHR-1:0][NUM_TC-1:0]      cur_closed,
  output logic [NPORT*NUM_TC-1:0]          gates_open
);

  // Lowest-numbered thread targeting a port decides its gates
  always_comb begin
    logic [NUM_TC-1:0] g;
    for (int p = 0; p < NPORT; p++) begin
      g = '1;
      for (int t = NTHR - 1; t >= 0; t--) begin
        if (live[t] && cur_ports[t][p]) g = ~cur_closed[t];
      end
      gates_open[p*NUM_TC +: NUM_TC] = g;
    end
  end

endmodule

// File: rtl/tgs_engine.sv
module tgs_engine
  import tgs_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int NPORT   = 5,
  parameter int NTHR    = 8,
  parameter int TIME_W  = 32,
  parameter int MAX_DUR = 2**19,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int DUR_W  = $clog2(MAX_DUR) + 1,
  localparam int THR_W  = $clog2(NTHR)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic                     tick,
  input  logic [TIME_W-1:0]        time_now,
  input  logic                     ent_we,
  input  logic [IDX_W-1:0]         ent_addr,
  input  logic [DUR_W-1:0]         ent_dur,
  input  logic [NPORT-1:0]         ent_ports,
  input  logic [NUM_TC-1:0]        ent_closed,
  input  logic                     thr_we,
  input  logic [THR_W-1:0]         thr_sel,
  input  logic [IDX_W-1:0]         thr_start,
  input  logic [IDX_W-1:0]         thr_end,
  input  logic [TIME_W-1:0]        thr_offset,
  input  logic                     glb_we,
  input  logic [1:0]               glb_src,
  input  logic [THR_W-1:0]         glb_act_m1,
  output logic [NPORT*NUM_TC-1:0]  gates_open,
  output logic                     collision
);

  logic [DEPTH-1:0][DUR_W-1:0]   e_dur;
  logic [DEPTH-1:0][NPORT-1:0]   e_ports;
  logic [DEPTH-1:0][NUM_TC-1:0]  e_closed;
  logic [NTHR-1:0][IDX_W-1:0]    t_start;
  logic [NTHR-1:0][IDX_W-1:0]    t_end;
  logic [NTHR-1:0][TIME_W-1:0]   t_off;
  logic [THR_W-1:0]              act_m1;
  logic                          cfg_ok;
  logic                          running;

  logic [NTHR-1:0][IDX_W-1:0]    thr_idx;
  logic [NTHR-1:0][IDX_W-1:0]    thr_nxt;
  logic [NTHR-1:0]               thr_started;
  logic [NTHR-1:0]               thr_evt;
  logic [NTHR-1:0]               thr_live;
  logic [NTHR-1:0][NPORT-1:0]    cur_ports;
  logic [NTHR-1:0][NUM_TC-1:0]   cur_closed;

  tgs_cfg_store #(
    .DEPTH(DEPTH), .NPORT(NPORT), .NTHR(NTHR),
    .TIME_W(TIME_W), .MAX_DUR(MAX_DUR)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_ok(!enable),
    .ent_we(ent_we), .ent_addr(ent_addr), .ent_dur(ent_dur),
    .ent_ports(ent_ports), .ent_closed(ent_closed),
    .thr_we(thr_we), .thr_sel(thr_sel), .thr_start(thr_start),
    .thr_end(thr_end), .thr_offset(thr_offset),
    .glb_we(glb_we), .glb_src(glb_src), .glb_act_m1(glb_act_m1),
    .e_dur(e_dur), .e_ports(e_ports), .e_closed(e_closed),
    .t_start(t_start), .t_end(t_end), .t_off(t_off),
    .act_m1(act_m1), .cfg_ok(cfg_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      collision <= 1'b0;
    end else begin
      running   <= enable && cfg_ok;
      collision <= enable && (collision || ($countones(thr_evt) > 1));
    end
  end

  for (genvar g = 0; g < NTHR; g++) begin : g_thr
    tgs_thread #(.IDX_W(IDX_W), .DUR_W(DUR_W), .TIME_W(TIME_W)) u_thr (
      .clk(clk), .rst_n(rst_n), .run(running),
      .act(g <= int'(act_m1)), .tick(tick), .time_now(time_now),
      .off(t_off[g]), .first(t_start[g]), .last(t_end[g]),
      .nxt_dur(e_dur[thr_nxt[g]]), .nxt_idx(thr_nxt[g]),
      .idx(thr_idx[g]), .started(thr_started[g]), .evt(thr_evt[g])
    );
    assign thr_live[g]   = running && thr_started[g];
    assign cur_ports[g]  = e_ports[thr_idx[g]];
    assign cur_closed[g] = e_closed[thr_idx[g]];
  end

  tgs_gate_mux #(.NPORT(NPORT), .NTHR(NTHR)) u_mux (
    .live(thr_live), .cur_ports(cur_ports),
    .cur_closed(cur_closed), .gates_open(gates_open)
  );

endmodule

// File: rtl/tgs_engine_chk.sv
module tgs_engine_chk #(
  parameter int NPORT = 5,
  parameter int NTHR  = 8,
  parameter int IDX_W = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      enable,
  input logic                      running,
  input logic                      collision,
  input logic [NPORT*8-1:0]        gates_open,
  input logic [NTHR-1:0]           thr_evt,
  input logic [NTHR-1:0]           thr_started,
  input logic [NTHR-1:0][IDX_W-1:0] thr_idx,
  input logic [NTHR-1:0][IDX_W-1:0] t_start,
  input logic [NTHR-1:0][IDX_W-1:0] t_end
);

  // R10
  idle_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (gates_open == '1));

  // R10
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> (thr_started == '0));

  // R9
  coll_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    collision && enable |=> collision);

  // R9
  coll_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable && ($countones(thr_evt) > 1) |=> collision);

  for (genvar g = 0; g < NTHR; g++) begin : g_chk
    // R4
    slice_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      running && thr_started[g] |-> (thr_idx[g] >= t_start[g] && thr_idx[g] <= t_end[g]));
  end

endmodule

bind tgs_engine tgs_engine_chk #(.NPORT(NPORT), .NTHR(NTHR), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .running(running),
  .collision(collision), .gates_open(gates_open), .thr_evt(thr_evt),
  .thr_started(thr_started), .thr_idx(thr_idx),
  .t_start(t_start), .t_end(t_end)
);

// File: tb/tb_tgs_engine.sv
module tb_tgs_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        tick = 1'b0;
  logic [31:0] time_now = '0;
  logic        ent_we = 1'b0;
  logic [3:0]  ent_addr = '0;
  logic [19:0] ent_dur = '0;
  logic [4:0]  ent_ports = '0;
  logic [7:0]  ent_closed = '0;
  logic        thr_we = 1'b0;
  logic [2:0]  thr_sel = '0;
  logic [3:0]  thr_start = '0;
  logic [3:0]  thr_end = '0;
  logic [31:0] thr_offset = '0;
  logic        glb_we = 1'b0;
  logic [1:0]  glb_src = '0;
  logic [2:0]  glb_act_m1 = '0;
  logic [39:0] gates_open;
  logic        collision;

  int tests = 0;
  int fails = 0;
  int tc = 0;

  always #5 clk = ~clk;

  tgs_engine dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .time_now(time_now),
    .ent_we(ent_we), .ent_addr(ent_addr), .ent_dur(ent_dur),
    .ent_ports(ent_ports), .ent_closed(ent_closed),
    .thr_we(thr_we), .thr_sel(thr_sel), .thr_start(thr_start),
    .thr_end(thr_end), .thr_offset(thr_offset),
    .glb_we(glb_we), .glb_src(glb_src), .glb_act_m1(glb_act_m1),
    .gates_open(gates_open), .collision(collision)
  );

  // {port2, port1, port0} after the tick at time t; ports 3 and 4 stay FF
  localparam logic [23:0] VEC [12] = '{
    24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF,
    24'hFFFFF0, 24'hFEFEF0, 24'hFE0F0F, 24'hFEFEF0, 24'hFEFEF0,
    24'hFE0F0F, 24'hFEFEF0
  };

  task automatic chk(input string req, input logic [40:0] got, input logic [40:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr_ent(input int a, input logic [19:0] d, input logic [4:0] p, input logic [7:0] c);
    ent_we = 1'b1; ent_addr = 4'(a); ent_dur = d; ent_ports = p; ent_closed = c;
    @(negedge clk);
    ent_we = 1'b0;
  endtask

  task automatic wr_thr(input int s, input int st, input int en, input int off);
    thr_we = 1'b1; thr_sel = 3'(s); thr_start = 4'(st); thr_end = 4'(en); thr_offset = off;
    @(negedge clk);
    thr_we = 1'b0;
  endtask

  task automatic wr_glb(input int src, input int act);
    glb_we = 1'b1; glb_src = 2'(src); glb_act_m1 = 3'(act);
    @(negedge clk);
    glb_we = 1'b0;
  endtask

  task automatic set_unused_end(input int from, input int en);
    for (int t = from; t < 8; t++) wr_thr(t, 0, en, 1);
  endtask

  task automatic start_run();
    enable = 1'b1;
    @(negedge clk);
    tc = 0;
  endtask

  task automatic stop_run();
    enable = 1'b0;
    @(negedge clk);
  endtask

  task automatic step();
    tick = 1'b1; time_now = tc;
    @(negedge clk);
    tick = 1'b0;
    tc++;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  function automatic logic [40:0] exp_of(input logic coll, input logic [23:0] v);
    return {coll, 16'hFFFF, v};
  endfunction

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset", {collision, gates_open}, exp_of(1'b0, 24'hFFFFFF));
    rst_n = 1'b1;
    @(negedge clk);

    wr_ent(0, 20'd2, 5'b00001, 8'h0F);
    wr_ent(1, 20'd1, 5'b00011, 8'hF0);
    wr_ent(2, 20'd3, 5'b00110, 8'h01);
    wr_thr(0, 0, 1, 5);
    wr_thr(1, 2, 2, 6);
    set_unused_end(2, 2);
    wr_glb(1, 1);

    start_run();
    // R10 nothing before first tick
    chk("R10 pre-tick idle", {collision, gates_open}, exp_of(1'b0, 24'hFFFFFF));
    // R3 R4 R5 vector walk
    for (int t = 0; t < 12; t++) begin
      step();
      chk($sformatf("R3/R4/R5 vector t=%0d", t), {collision, gates_open}, exp_of(1'b0, VEC[t]));
    end

    // R2: write while enabled is ignored
    wr_ent(0, 20'd2, 5'b00001, 8'h00);   // consumes no tick
    step();                               // t=12
    chk("R2 locked write live", {collision, gates_open}, exp_of(1'b0, 24'hFEFEF0));
    stop_run();
    // R10: disable returns idle
    chk("R10 disable", {collision, gates_open}, exp_of(1'b0, 24'hFFFFFF));
    start_run();
    steps(6);                             // t0..t5
    chk("R2 locked write kept after reload", {collision, gates_open}, exp_of(1'b0, 24'hFFFFF0));
    stop_run();

    // R8: clock sources other than 1 are off
    wr_glb(2, 1);
    start_run(); steps(7);
    chk("R8 src=2 off", {collision, gates_open}, exp_of(1'b0, 24'hFFFFFF));
    stop_run();
    wr_glb(0, 1);
    start_run(); steps(7);
    chk("R8 src=0 off", {collision, gates_open}, exp_of(1'b0, 24'hFFFFFF));
    stop_run();
    wr_glb(1, 1);

    // R7: rejects
    wr_ent(1, 20'd0, 5'b00011, 8'hF0);
    start_run(); steps(8);
    chk("R7 zero duration", {collision, gates_open}, exp_of(1'b0, 24'hFFFFFF));
    stop_run();
    wr_ent(1, 20'd1, 5'b00011, 8'hF0);
    wr_ent(2, 20'h80000, 5'b00110, 8'h01);
    start_run(); steps(8);
    chk("R7 duration 2^19", {collision, gates_open}, exp_of(1'b0, 24'hFFFFFF));
    stop_run();
    wr_ent(2, 20'h7FFFF, 5'b00110, 8'h01);
    start_run(); steps(7);
    chk("R7 duration 2^19-1 accepted", {collision, gates_open}, exp_of(1'b0, 24'hFEFEF0));
    stop_run();
    wr_ent(2, 20'd3, 5'b00110, 8'h01);
    wr_thr(1, 2, 2, 0);
    start_run(); steps(8);
    chk("R7 zero offset", {collision, gates_open}, exp_of(1'b0, 24'hFFFFFF));
    stop_run();
    wr_thr(1, 2, 2, 6);
    wr_thr(0, 0, 3, 5);
    start_run(); steps(8);
    chk("R7 end indices decrease", {collision, gates_open}, exp_of(1'b0, 24'hFFFFFF));
    stop_run();
    wr_thr(0, 0, 1, 5);
    wr_thr(5, 0, 3, 1);
    start_run(); steps(8);
    chk("R7 unused end mismatch", {collision, gates_open}, exp_of(1'b0, 24'hFFFFFF));
    stop_run();
    wr_thr(5, 0, 2, 1);

    // R6: one active thread only
    wr_glb(1, 0);
    set_unused_end(1, 1);
    start_run(); steps(7);
    chk("R6 single thread", {collision, gates_open}, exp_of(1'b0, 24'hFFFFF0));
    stop_run();
    wr_glb(1, 1);
    wr_thr(1, 2, 2, 6);
    set_unused_end(2, 2);

    // R9: thread1 at offset 7 loads on the same tick as thread0
    wr_thr(1, 2, 2, 7);
    start_run(); steps(7);               // t0..t6
    chk("R9 no collision yet", {31'd0, collision}, 41'd0);
    step();                              // t7
    chk("R9 collision raised", {40'd0, collision}, 41'd1);
    steps(2);
    chk("R9 collision sticky", {40'd0, collision}, 41'd1);
    stop_run();
    chk("R9 collision cleared on disable", {collision, gates_open}, exp_of(1'b0, 24'hFFFFFF));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule